// File: doc/BRIEF.md
# Time-Sliced Section Scheduler for a Shared Image Converter

One image-conversion datapath is shared by three conversion tasks: encode pre-processing, viewfinder pre-processing and post-processing. The datapath has three pipeline sections: a downsizing stage, a main stage, and a rotation stage. The main stage does upsizing, flipping, colour conversion and plane combining. Each section is time-shared on its own. This block decides, for each section, which task owns it, and it keeps that ownership for one whole slice.

The slice size differs between sections. The downsizing stage counts pixel strobes and can change owner after every burst of `BURST_PIX` pixels. The default is eight. The main stage can change owner only when the datapath signals the end of a line. The rotation stage can change owner only when the datapath signals the end of a frame. Each section has its own round-robin pointer. When the current source is the motion-compensated deinterlacer, requests from the encode task are refused, because only the viewfinder task may take those frames.

Top module: `conv_slice_sched`

## Requirements
- R1: After reset, every grant vector is zero and each round-robin pointer starts at the encode task. With all three tasks requesting, the first grant in a section goes to the encode task. Task bits in every request and grant vector are: bit 0 encode, bit 1 viewfinder, bit 2 post-processing.
- R2: Each grant vector has at most one bit set.
- R3: While a section has no grant, its grant vector is zero. Any eligible request is granted on the clock edge that samples it, so the grant is visible the next cycle.
- R4: A downsizing grant is held until `BURST_PIX` pixel strobes (`pix_done`) have been counted while it is held. It changes owner on the edge that samples the last strobe of the burst.
- R5: A main-section grant changes owner only on an edge where `line_done` is high.
- R6: A rotation grant changes owner only on an edge where `frame_done` is high. Pixel and line strobes have no effect on it.
- R7: At the end of a slice, the next owner is the first requesting task after the task just served, in the cyclic order bit 0, bit 1, bit 2, bit 0. The new grant appears in the cycle right after the boundary strobe.
- R8: A task that drops its request in the middle of a slice keeps the grant until the slice ends. If no task is requesting at the slice end, the grant vector becomes zero.
- R9: While `src_deint` is high, the encode task (bit 0) receives no new grant in any section. The viewfinder and post-processing tasks are arbitrated as usual.
- R10: A boundary strobe for one section has no effect on the grants of the other sections.
- R11: Pixel strobes that arrive while the downsizing section has no grant are not counted toward the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_down | input | 3 | Per-task requests for the downsizing section |
| req_main | input | 3 | Per-task requests for the main section |
| req_rot | input | 3 | Per-task requests for the rotation section |
| src_deint | input | 1 | High when the frame source is the deinterlacer (blocks encode) |
| pix_done | input | 1 | One pixel finished in the downsizing section |
| line_done | input | 1 | One line finished in the main section |
| frame_done | input | 1 | One frame finished in the rotation section |
| gnt_down | output | 3 | One-hot owner of the downsizing section |
| gnt_main | output | 3 | One-hot owner of the main section |
| gnt_rot | output | 3 | One-hot owner of the rotation section |

## Verification
The bench builds the block with the default `BURST_PIX` of 8. This makes the burst boundary fall exactly on the eighth strobe, with an off-by-one check on the seventh strobe. The short burst makes it practical to interleave idle-time pixel strobes and then confirm that they did not shorten the next burst. Line and frame strobes are driven one at a time, so the bench can confirm the pointer rotation, request skipping, the refusal of encode requests for deinterlaced frames, and isolation between sections.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

    localparam int NTASK = 3;
    localparam int NSECT = 3;

    localparam int TASK_ENC = 0;
    localparam int TASK_VF  = 1;
    localparam int TASK_PP  = 2;

    typedef enum logic [1:0] {
        SEC_DOWN = 2'd0,
        SEC_MAIN = 2'd1,
        SEC_ROT  = 2'd2
    } sect_e;

    typedef logic [NTASK-1:0]         tmask_t;
    typedef logic [$clog2(NTASK)-1:0] tidx_t;

    typedef struct packed {
        tmask_t gnt;
        tidx_t  ptr;
    } slice_state_t;

    // First requester at or after 'start' in cyclic order.
    function automatic tmask_t rr_pick(tmask_t req, tidx_t start);
        tmask_t r;
        r = '0;
        for (int k = 0; k < NTASK; k++) begin
            int idx;
            idx = (int'(start) + k) % NTASK;
            if (r == '0 && req[idx]) r[idx] = 1'b1;
        end
        return r;
    endfunction

    // Index following the task that holds a one-hot grant.
    function automatic tidx_t after_owner(tmask_t g);
        tidx_t n;
        n = '0;
        for (int k = 0; k < NTASK; k++) begin
            if (g[k]) n = tidx_t'((k + 1) % NTASK);
        end
        return n;
    endfunction

endpackage

// File: rtl/src_req_gate.sv
module src_req_gate
    import tsched_pkg::*;
(
    input  tmask_t req_in,
    input  logic   src_deint,
    output tmask_t req_out
);
    tmask_t block;

    always_comb begin
        block = '0;
        block[TASK_ENC] = src_deint;
        req_out = req_in & ~block;
    end
endmodule

// File: rtl/slice_boundary.sv
module slice_boundary #(
    parameter bit COUNTED = 1'b0,
    parameter int BURST   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic strobe,
    output logic slice_end
);
    generate
        if (COUNTED) begin : g_count
            localparam int CW = (BURST > 1) ? $clog2(BURST) : 1;
            localparam logic [CW-1:0] LAST = CW'(BURST - 1);
            logic [CW-1:0] cnt;

            assign slice_end = active && strobe && (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (slice_end) begin
                    cnt <= '0;
                end else if (active && strobe) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else begin : g_direct
            assign slice_end = active && strobe;
        end
    endgenerate
endmodule

// File: rtl/slice_arbiter.sv
module slice_arbiter
    import tsched_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tmask_t req,
    input  logic   slice_end,
    output tmask_t gnt
);
    slice_state_t st, st_nxt;

    always_comb begin
        st_nxt = st;
        if (st.gnt == '0) begin
            st_nxt.gnt = rr_pick(req, st.ptr);
        end else if (slice_end) begin
            st_nxt.ptr = after_owner(st.gnt);
            st_nxt.gnt = rr_pick(req, after_owner(st.gnt));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.gnt <= '0;
            st.ptr <= tidx_t'(TASK_ENC);
        end else begin
            st <= st_nxt;
        end
    end

    assign gnt = st.gnt;
endmodule

// File: rtl/conv_slice_sched.sv
module conv_slice_sched
    import tsched_pkg::*;
#(
    parameter int BURST_PIX = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] req_down,
    input  logic [2:0] req_main,
    input  logic [2:0] req_rot,
    input  logic       src_deint,
    input  logic       pix_done,
    input  logic       line_done,
    input  logic       frame_done,
    output logic [2:0] gnt_down,
    output logic [2:0] gnt_main,
    output logic [2:0] gnt_rot
);
    tmask_t req_raw [NSECT];
    tmask_t req_ok  [NSECT];
    tmask_t gnt_arr [NSECT];
    logic   strobe  [NSECT];
    logic   s_end   [NSECT];

    assign req_raw[SEC_DOWN] = req_down;
    assign req_raw[SEC_MAIN] = req_main;
    assign req_raw[SEC_ROT]  = req_rot;
    assign strobe[SEC_DOWN]  = pix_done;
    assign strobe[SEC_MAIN]  = line_done;
    assign strobe[SEC_ROT]   = frame_done;

    generate
        for (genvar s = 0; s < NSECT; s++) begin : g_sect
            src_req_gate u_gate (
                .req_in    (req_raw[s]),
                .src_deint (src_deint),
                .req_out   (req_ok[s])
            );

            slice_boundary #(
                .COUNTED (s == int'(SEC_DOWN)),
                .BURST   (BURST_PIX)
            ) u_bnd (
                .clk       (clk),
                .rst       (rst),
                .active    (gnt_arr[s] != '0),
                .strobe    (strobe[s]),
                .slice_end (s_end[s])
            );

            slice_arbiter u_arb (
                .clk       (clk),
                .rst       (rst),
                .req       (req_ok[s]),
                .slice_end (s_end[s]),
                .gnt       (gnt_arr[s])
            );
        end
    endgenerate

    assign gnt_down = gnt_arr[SEC_DOWN];
    assign gnt_main = gnt_arr[SEC_MAIN];
    assign gnt_rot  = gnt_arr[SEC_ROT];
endmodule

// File: rtl/conv_slice_sched_chk.sv
module conv_slice_sched_chk #(
    parameter int BURST_PIX = 8
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] req_down,
    input logic [2:0] req_main,
    input logic [2:0] req_rot,
    input logic       src_deint,
    input logic       pix_done,
    input logic       line_done,
    input logic       frame_done,
    input logic [2:0] gnt_down,
    input logic [2:0] gnt_main,
    input logic [2:0] gnt_rot
);
    logic [2:0] enc_blk;
    assign enc_blk = {2'b00, src_deint};

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_down) && $onehot0(gnt_main) && $onehot0(gnt_rot));

    assert_idle_grant_R3: assert property (@(posedge clk) disable iff (rst)
        (gnt_main == 3'b000 && (req_main & ~enc_blk) != 3'b000) |=> gnt_main != 3'b000);

    assert_idle_stay_R3: assert property (@(posedge clk) disable iff (rst)
        (gnt_rot == 3'b000 && req_rot == 3'b000) |=> gnt_rot == 3'b000);

    assert_down_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt_down != 3'b000 && !pix_done) |=> gnt_down == $past(gnt_down));

    assert_main_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt_main != 3'b000 && !line_done) |=> gnt_main == $past(gnt_main));

    assert_rot_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (gnt_rot != 3'b000 && !frame_done) |=> gnt_rot == $past(gnt_rot));

    assert_rr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (gnt_main == 3'b001 && line_done && req_main == 3'b111 && !src_deint)
        |=> gnt_main == 3'b010);

    assert_enc_block_R9: assert property (@(posedge clk) disable iff (rst)
        (src_deint && !gnt_main[0]) |=> !gnt_main[0]);

    assert_enc_block_rot_R9: assert property (@(posedge clk) disable iff (rst)
        (src_deint && !gnt_rot[0]) |=> !gnt_rot[0]);
endmodule

bind conv_slice_sched conv_slice_sched_chk #(.BURST_PIX(BURST_PIX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_down   (req_down),
    .req_main   (req_main),
    .req_rot    (req_rot),
    .src_deint  (src_deint),
    .pix_done   (pix_done),
    .line_done  (line_done),
    .frame_done (frame_done),
    .gnt_down   (gnt_down),
    .gnt_main   (gnt_main),
    .gnt_rot    (gnt_rot)
);

// File: tb/tb_conv_slice_sched.sv
`timescale 1ns/1ps
module tb_conv_slice_sched;

    localparam int BURST = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req_down = '0, req_main = '0, req_rot = '0;
    logic       src_deint = 1'b0;
    logic       pix_done = 1'b0, line_done = 1'b0, frame_done = 1'b0;
    logic [2:0] gnt_down, gnt_main, gnt_rot;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    conv_slice_sched #(.BURST_PIX(BURST)) dut (
        .clk(clk), .rst(rst),
        .req_down(req_down), .req_main(req_main), .req_rot(req_rot),
        .src_deint(src_deint),
        .pix_done(pix_done), .line_done(line_done), .frame_done(frame_done),
        .gnt_down(gnt_down), .gnt_main(gnt_main), .gnt_rot(gnt_rot)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        req_down = '0; req_main = '0; req_rot = '0;
        src_deint = 1'b0; pix_done = 1'b0; line_done = 1'b0; frame_done = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic pulse_line();
        line_done = 1'b1; step(1); line_done = 1'b0;
    endtask

    task automatic pulse_pix();
        pix_done = 1'b1; step(1); pix_done = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        step(1);
        chk("R1 down after reset", gnt_down, 3'b000);
        chk("R1 main after reset", gnt_main, 3'b000);
        chk("R1 rot after reset",  gnt_rot,  3'b000);
    endtask

    task automatic test_idle();
        do_reset();
        step(3);
        chk("R3 idle main zero", gnt_main, 3'b000);
        req_main = 3'b100;
        step(1);
        chk("R3 grant next cycle", gnt_main, 3'b100);
    endtask

    task automatic test_rr_main();
        do_reset();
        req_main = 3'b111;
        step(1);
        chk("R1 encode first", gnt_main, 3'b001);
        chk("R2 onehot", {2'b00, $countones(gnt_main) <= 1}, 3'b001);
        pulse_line();
        chk("R7 enc->vf", gnt_main, 3'b010);
        step(3);
        chk("R5 hold without line end", gnt_main, 3'b010);
        pulse_line();
        chk("R7 vf->pp", gnt_main, 3'b100);
        pulse_line();
        chk("R7 pp->enc wrap", gnt_main, 3'b001);
        req_main = 3'b101;
        pulse_line();
        chk("R7 skip idle vf", gnt_main, 3'b100);
    endtask

    task automatic test_burst();
        do_reset();
        req_down = 3'b011;
        step(1);
        chk("R4 first owner", gnt_down, 3'b001);
        for (int i = 0; i < BURST - 1; i++) begin
            pulse_pix();
            step(1);
        end
        chk("R4 held before last pixel", gnt_down, 3'b001);
        pulse_pix();
        chk("R4 switch after burst", gnt_down, 3'b010);
    endtask

    task automatic test_rot();
        do_reset();
        req_rot = 3'b110;
        step(1);
        chk("R6 first owner", gnt_rot, 3'b010);
        pulse_line();
        pulse_pix();
        chk("R6 line/pixel no effect", gnt_rot, 3'b010);
        frame_done = 1'b1; step(1); frame_done = 1'b0;
        chk("R6 switch on frame end", gnt_rot, 3'b100);
    endtask

    task automatic test_drop();
        do_reset();
        req_main = 3'b001;
        step(1);
        chk("R8 granted", gnt_main, 3'b001);
        req_main = 3'b000;
        step(3);
        chk("R8 kept after drop", gnt_main, 3'b001);
        pulse_line();
        chk("R8 released at slice end", gnt_main, 3'b000);
    endtask

    task automatic test_deint();
        do_reset();
        src_deint = 1'b1;
        req_main = 3'b001;
        step(2);
        chk("R9 encode refused", gnt_main, 3'b000);
        req_main = 3'b011;
        step(1);
        chk("R9 viewfinder granted", gnt_main, 3'b010);
        req_down = 3'b101;
        step(1);
        chk("R9 post granted in down", gnt_down, 3'b100);
    endtask

    task automatic test_indep();
        do_reset();
        req_down = 3'b111; req_main = 3'b111;
        step(1);
        pulse_line();
        chk("R10 main moved", gnt_main, 3'b010);
        chk("R10 down untouched", gnt_down, 3'b001);
    endtask

    task automatic test_idle_strobes();
        do_reset();
        for (int i = 0; i < 5; i++) pulse_pix();
        chk("R11 no grant when idle", gnt_down, 3'b000);
        req_down = 3'b011;
        step(1);
        chk("R11 granted", gnt_down, 3'b001);
        for (int i = 0; i < BURST - 1; i++) pulse_pix();
        chk("R11 idle strobes not counted", gnt_down, 3'b001);
        pulse_pix();
        chk("R11 switch on full burst", gnt_down, 3'b010);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        test_reset();
        test_idle();
        test_rr_main();
        test_burst();
        test_rot();
        test_drop();
        test_deint();
        test_indep();
        test_idle_strobes();
        step(2);
        finish_run();
    end
endmodule